// File: doc/BRIEF.md
# Timestamp Snapshot Capture Unit

This peripheral runs five free-running time counters and, on request from software, copies all of them on a single clock edge into a bank of read-only snapshot registers. Software reads those registers afterwards without any risk of tearing. Access goes through a plain 32-bit register port that is word addressed. Reads are combinational from the address. A write takes effect on the clock edge at which `reg_we` is high. Every access completes in one cycle, and the port has no back-pressure.

Software starts a capture by writing a control word with exactly one of two trigger bits set: a host-initiated request or an on-demand request. The trigger bit reads back as set while the capture is in progress. On the next edge the counters are latched, the trigger bit clears and a completion flag rises. The flag is cleared by writing 1 to it. While the flag is set, the snapshot bank is frozen and new triggers are refused. When the interrupt enable is set, an interrupt pin follows the flag.

Top module: `tsu_snapshot_unit`

## Requirements
- R1: While reset is asserted and right after it, the control word reads 0, every snapshot word reads 0 and `irq` is low.
- R2: Counter k holds INIT[k] + STEP[k]·n after n clock edges out of reset. Counters 0 and 4 are 32 bits wide and wrap modulo 2^32. Counters 1, 2 and 3 are 64 bits wide and carry into their upper word.
- R3: A control write (word 0) whose bits [1:0] are 01 or 10, made while idle with the flag clear, stores that trigger bit. The bit reads back set for one cycle. On the next edge it clears and the completion flag (bit 2) becomes 1.
- R4: A control write with bits [1:0] = 11 stores neither trigger bit and starts no capture.
- R5: While a trigger bit is set, any control write is ignored completely, including its configuration fields.
- R6: Writing 1 to bit 2 clears the flag. Writing 0 to bit 2 leaves it unchanged.
- R7: The five snapshots hold the values the counters had on the capture edge. They do not change while the flag is set.
- R8: A trigger write made while the flag is set is ignored. No trigger bit is stored and the snapshots keep their contents.
- R9: `irq` is high exactly when the flag is set and the interrupt enable (bit 3) is 1.
- R10: An accepted control write stores the configuration fields, and they read back at these positions: interrupt enable [3], DMA type [4], link select [7:5], link wall-clock select [8], DMA select [12:9]. Bits [31:13] read 0.
- R11: Snapshot words sit at these word addresses: 1 = sample count, 2/3 = link sample count low/high, 4/5 = wall clock low/high, 6/7 = always-running timer low/high, 8 = link wall clock. Addresses 9 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | New-snapshot interrupt |

## Verification
A trigger state that gets stuck shows up on the very next control read as a trigger bit that stays set past its single cycle. It also shows up as a flag that never rises, or as `irq` staying low. A capture edge that is off by one cycle, or a counter that latches on its own edge, makes a snapshot word differ from INIT + STEP·n as soon as that word is read. The 32-bit wrap and the 64-bit carries turn low/high tearing into a visible error. A leak of the freeze or of the busy window changes a snapshot or configuration field on the first read that follows the ignored write.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
  localparam int DATA_W = 32;
  localparam int AW     = 4;
  localparam int NCNT   = 5;
  localparam int LSEL_W = 3;
  localparam int DSEL_W = 4;

  // control word bit positions (behavioural: software decodes them)
  localparam int B_HOST    = 0;
  localparam int B_DEM     = 1;
  localparam int B_NEW     = 2;
  localparam int B_IEN     = 3;
  localparam int B_DTYP    = 4;
  localparam int B_LSEL    = 5;
  localparam int B_LWS     = B_LSEL + LSEL_W;
  localparam int B_DSEL    = B_LWS + 1;
  localparam int CTRL_USED = B_DSEL + DSEL_W;

  localparam logic [AW-1:0] W_CTRL = '0;

  // which counters are 64 bits wide (order fixes the word map)
  localparam logic [NCNT-1:0] CNT_WIDE = 5'b01110;

  typedef struct packed {
    logic [DSEL_W-1:0] dma_sel;
    logic              lw_sel;
    logic [LSEL_W-1:0] link_sel;
    logic              dma_type;
    logic              irq_en;
  } cfg_t;

  function automatic int word_base(int idx);
    int s = 0;
    for (int j = 0; j < idx; j++) s += CNT_WIDE[j] ? 2 : 1;
    return s;
  endfunction

  localparam int NWORD = word_base(NCNT);
endpackage

// File: rtl/tsu_counters.sv
module tsu_counters
  import tsu_pkg::*;
#(
  parameter logic [NCNT-1:0][63:0] STEP = '0,
  parameter logic [NCNT-1:0][63:0] INIT = '0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  output logic [NWORD-1:0][DATA_W-1:0]  words
);
  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    localparam int BASE = word_base(i);
    if (CNT_WIDE[i]) begin : g_wide
      logic [63:0] r;
      always_ff @(posedge clk) begin
        if (!rst_n) r <= INIT[i];
        else        r <= r + STEP[i];
      end
      assign words[BASE]   = r[31:0];
      assign words[BASE+1] = r[63:32];
    end else begin : g_narrow
      logic [31:0] r;
      always_ff @(posedge clk) begin
        if (!rst_n) r <= INIT[i][31:0];
        else        r <= r + STEP[i][31:0];
      end
      assign words[BASE] = r;
    end
  end
endmodule

// File: rtl/tsu_ctrl.sv
module tsu_ctrl
  import tsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_USED-1:0] wdata,
  output logic [1:0]        trig,
  output logic              flag,
  output cfg_t              cfg,
  output logic              cap
);
  logic busy;
  logic one_trig;

  assign busy     = trig[0] | trig[1];
  assign one_trig = wdata[B_HOST] ^ wdata[B_DEM];
  assign cap      = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig <= '0;
      flag <= 1'b0;
      cfg  <= '0;
    end else if (busy) begin
      // completion edge: counters latch now
      trig <= '0;
      flag <= 1'b1;
    end else if (ctrl_wr) begin
      cfg <= cfg_t'(wdata[CTRL_USED-1:B_IEN]);
      if (wdata[B_NEW]) flag <= 1'b0;
      if (!flag && one_trig) trig <= wdata[B_DEM:B_HOST];
    end
  end

  p_trig_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trig));
  p_trig_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig != 2'b00) |=> (trig == 2'b00 && flag));
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(ctrl_wr && wdata[B_NEW])) |=> flag);
  p_no_trig_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag |=> (trig == 2'b00));
  p_busy_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig != 2'b00) |=> $stable(cfg));
endmodule

// File: rtl/tsu_snap.sv
module tsu_snap
  import tsu_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cap,
  input  logic                          flag,
  input  logic [NWORD-1:0][DATA_W-1:0]  words,
  input  logic [AW-1:0]                 widx,
  output logic [DATA_W-1:0]             rdata
);
  localparam int IW = (NWORD > 1) ? $clog2(NWORD) : 1;

  logic [NWORD-1:0][DATA_W-1:0] snap;
  logic [AW-1:0]                off;

  always_ff @(posedge clk) begin
    if (!rst_n)   snap <= '0;
    else if (cap) snap <= words;
  end

  assign off = widx - AW'(1);

  always_comb begin
    rdata = '0;
    if (off < AW'(NWORD)) rdata = snap[off[IW-1:0]];
  end

  p_snap_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag |=> $stable(snap));
endmodule

// File: rtl/tsu_snapshot_unit.sv
module tsu_snapshot_unit
  import tsu_pkg::*;
#(
  parameter logic [NCNT-1:0][63:0] CNT_STEP = {64'd11, 64'd5, 64'd7, 64'd3, 64'd1},
  parameter logic [NCNT-1:0][63:0] CNT_INIT = {64'h0000_0000_FFFF_FFF0,
                                               64'h0000_0002_FFFF_FFC0,
                                               64'h0000_0001_FFFF_FF80,
                                               64'h0000_00AB_0000_0000,
                                               64'd100}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [NWORD-1:0][DATA_W-1:0] words;
  logic [1:0]        trig;
  logic              flag;
  logic              cap;
  cfg_t              cfg;
  logic              ctrl_wr;
  logic [DATA_W-1:0] snap_rd;
  logic [DATA_W-1:0] ctrl_rd;
  logic              unused_wbits;

  assign unused_wbits = ^reg_wdata[DATA_W-1:CTRL_USED];
  assign ctrl_wr      = reg_we && (reg_addr == W_CTRL);

  tsu_counters #(.STEP(CNT_STEP), .INIT(CNT_INIT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .words(words));

  tsu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
    .wdata(reg_wdata[CTRL_USED-1:0]),
    .trig(trig), .flag(flag), .cfg(cfg), .cap(cap));

  tsu_snap u_snap (
    .clk(clk), .rst_n(rst_n), .cap(cap), .flag(flag),
    .words(words), .widx(reg_addr), .rdata(snap_rd));

  assign ctrl_rd   = {{(DATA_W-CTRL_USED){1'b0}}, cfg, flag, trig};
  assign reg_rdata = (reg_addr == W_CTRL) ? ctrl_rd : snap_rd;
  assign irq       = flag & cfg.irq_en;

  p_irq_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
endmodule

// File: tb/sim_tsu_snapshot_unit.sv
module sim_tsu_snapshot_unit;
  localparam logic [4:0][63:0] STEP = {64'd11, 64'd5, 64'd7, 64'd3, 64'd1};
  localparam logic [4:0][63:0] INIT = {64'h0000_0000_FFFF_FFF0,
                                       64'h0000_0002_FFFF_FFC0,
                                       64'h0000_0001_FFFF_FF80,
                                       64'h0000_00AB_0000_0000,
                                       64'd100};
  localparam logic [4:0] WIDE = 5'b01110;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        we = 0;
  logic [3:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        irq;
  longint      cyc = 0;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 0;

  typedef struct { bit is_irq; logic [31:0] exp; string tag; } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  tsu_snapshot_unit #(.CNT_STEP(STEP), .CNT_INIT(INIT)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq));

  // monitor: compares outputs just after each falling edge
  always @(negedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = it.is_irq ? {31'b0, irq} : rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  function automatic logic [63:0] cval(int i, longint c);
    logic [63:0] v;
    v = INIT[i] + STEP[i] * 64'(c);
    if (!WIDE[i]) v[63:32] = '0;
    return v;
  endfunction

  function automatic logic [31:0] snapw(int k, longint c);
    logic [63:0] v;
    case (k)
      1: v = cval(0, c);
      2: v = cval(1, c);
      3: begin v = cval(1, c); v[31:0] = v[63:32]; end
      4: v = cval(2, c);
      5: begin v = cval(2, c); v[31:0] = v[63:32]; end
      6: v = cval(3, c);
      7: begin v = cval(3, c); v[31:0] = v[63:32]; end
      8: v = cval(4, c);
      default: v = '0;
    endcase
    return v[31:0];
  endfunction

  // driver tasks: always entered and left at a falling edge
  task automatic chk_rd(input logic [3:0] a, input logic [31:0] e, input string t);
    we = 0; addr = a;
    q.push_back('{1'b0, e, t});
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    q.push_back('{1'b1, {31'b0, e}, t});
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic chk_all_snap(input longint c, input string t);
    for (int k = 1; k <= 8; k++) chk_rd(4'(k), snapw(k, c), t);
  endtask

  localparam logic [31:0] CFG = (32'd1 << 3) | (32'd1 << 4) | (32'd5 << 5)
                              | (32'd1 << 8) | (32'd9 << 9);

  initial begin
    longint c1, c2, c3;
    @(negedge clk);
    // R1: values under reset
    chk_rd(0, 32'h0, "R1 ctrl");
    chk_rd(1, 32'h0, "R1 snap");
    chk_rd(5, 32'h0, "R1 snap");
    chk_irq(0, "R1 irq");
    rst_n = 1;
    chk_rd(0, 32'h0, "R1 ctrl after reset");

    // R10: configuration only
    wr(0, CFG);
    chk_rd(0, CFG, "R10 cfg readback");
    chk_irq(0, "R9 irq low without flag");

    // R3/R7/R2/R11: host capture
    wr(0, CFG | 32'h1);
    c1 = cyc;
    chk_rd(0, CFG | 32'h1, "R3 trigger set while busy");
    chk_rd(0, CFG | 32'h4, "R3 trigger cleared flag set");
    chk_irq(1, "R9 irq with enable");
    chk_all_snap(c1, "R7 R2 R11 capture one");
    chk_rd(12, 32'h0, "R11 unmapped");

    // R8: trigger while flag set
    wr(0, CFG | 32'h2);
    chk_rd(0, CFG | 32'h4, "R8 trigger refused");
    chk_rd(0, CFG | 32'h4, "R8 no capture");
    chk_all_snap(c1, "R8 R7 snapshot frozen");

    // R6: writing 0 to the flag
    wr(0, CFG);
    chk_rd(0, CFG | 32'h4, "R6 write 0 keeps flag");
    wr(0, CFG | 32'h4);
    chk_rd(0, CFG, "R6 write 1 clears flag");
    chk_irq(0, "R9 irq follows flag");

    // R4: both triggers
    wr(0, CFG | 32'h3);
    chk_rd(0, CFG, "R4 both bits rejected");
    chk_rd(0, CFG, "R4 no flag");
    chk_rd(2, snapw(2, c1), "R4 snapshot kept");

    // R5: write during the busy cycle is ignored; later capture shows carries
    repeat (30) @(negedge clk);
    we = 1; addr = 0; wdata = CFG | 32'h2;
    @(negedge clk);
    c2 = cyc;
    wdata = 32'h0;
    @(negedge clk);
    we = 0;
    chk_rd(0, CFG | 32'h4, "R5 busy write ignored");
    chk_all_snap(c2, "R7 R2 capture two");

    // R9: enable cleared, capture still completes, irq stays low
    wr(0, 32'h4);
    chk_rd(0, 32'h0, "R6 R10 clear flag and cfg");
    wr(0, 32'h1);
    c3 = cyc;
    chk_rd(0, 32'h1, "R3 second host trigger");
    chk_irq(0, "R9 irq disabled");
    chk_rd(0, 32'h4, "R3 flag after capture");
    chk_rd(8, snapw(8, c3), "R2 narrow wrap");
    chk_rd(7, snapw(7, c3), "R2 wide carry");

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule